// File: doc/BRIEF.md
# Bus Breakpoint Address Comparator

This block monitors a 16-bit processor address bus together with its direction strobe. It reports a breakpoint hit when a valid bus cycle meets the conditions that software has programmed. There are two comparator channels. Each channel holds a high and a low address byte. Each channel can ignore its low byte, so that one breakpoint covers a whole 256-byte page. Each channel can also require a particular bus direction.

A mode bit selects how the channels are used. In full mode, channel 0 alone defines the single breakpoint and channel 1 stays silent. In dual mode, the two channels run independently, and each has its own address and direction qualification. A global enable bit gates both outputs.

Configuration goes through a byte-wide register port with a write strobe and a combinational read path. The bus side is a plain monitor with no back-pressure. A cycle counts only when `bus_valid` is high, and the monitored bus is never stalled. Each match output is a registered pulse that is high for exactly the cycle after each qualifying bus cycle.

Top module: `bus_brk_cmp`

## Requirements
- R1: After reset, every register reads 0 and both match outputs are low.
- R2: When the global enable (offset 0 bit 0) is 0, neither match output is ever high, whatever the other settings are.
- R3: A channel reports a match only for a cycle with `bus_valid` high whose `bus_addr[15:8]` equals the channel's high byte. The match output goes high on the clock edge that samples that cycle and stays high for that one cycle only.
- R4: A channel's low-byte enable is offset 0 bit 2 for channel 0 and bit 3 for channel 1. When it is 1, `bus_addr[7:0]` must also equal the channel's low byte. When it is 0, the low byte has no effect on the match.
- R5: When a channel's direction-compare enable is 0, a match is reported on both read and write cycles.
- R6: When a channel's direction-compare enable is 1, its direction value selects the cycle type: 0 matches only write cycles (`bus_read`=0) and 1 matches only read cycles (`bus_read`=1). Channel 0 obeys its direction qualification in both modes.
- R7: In full mode (offset 0 bit 1 = 0), `match1` stays low and only channel 0 is reported.
- R8: In dual mode (offset 0 bit 1 = 1), channel 1 matches on its own address, low-byte enable and direction qualification, independently of channel 0.
- R9: A register write takes effect on the clock edge that samples it. A bus cycle sampled on that same edge is compared against the old register values.
- R10: The register map is as follows.
  - Offset 0 holds the control bits in [3:0].
  - Offset 1 holds {ch1 direction enable, ch1 direction value, ch0 direction enable, ch0 direction value} in bits [3:0], most significant first.
  - Offsets 2 and 3 hold the channel 0 high and low bytes.
  - Offsets 4 and 5 hold the channel 1 high and low bytes.
  - Unused bits read 0. Offsets 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| bus_valid | input | 1 | Monitored bus cycle is valid |
| bus_addr | input | 16 | Monitored address |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| match0 | output | 1 | Channel 0 breakpoint pulse |
| match1 | output | 1 | Channel 1 breakpoint pulse (dual mode only) |

## Verification
The assertions check the following on every cycle:
- no pulse follows an invalid cycle, a disabled block or a high-byte mismatch;
- no pulse follows a low-byte mismatch while the low-byte enable is 1;
- no pulse follows a wrong-direction cycle while direction compare is active;
- `match1` stays quiet in full mode;
- a written byte lands in its register.

Only the bench's sweeps can show the positive side: that a pulse does appear for each legal combination of mode, enables and bus pattern. The bench also covers the same-edge write ordering and the read-back layout of the register map.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int SEL_W  = 3;
  localparam int N_CH   = 2;

  localparam logic [SEL_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] OFF_DIR  = 3'd1;
  localparam logic [SEL_W-1:0] OFF_C0HI = 3'd2;
  localparam logic [SEL_W-1:0] OFF_C0LO = 3'd3;
  localparam logic [SEL_W-1:0] OFF_C1HI = 3'd4;
  localparam logic [SEL_W-1:0] OFF_C1LO = 3'd5;

  typedef struct packed {
    logic              dir_en;
    logic              dir_rd;
    logic              lo_en;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } chan_cfg_t;
endpackage

// File: rtl/bbc_regfile.sv
module bbc_regfile
  import bbc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       reg_sel,
  input  logic                   reg_wr,
  input  logic [BYTE_W-1:0]      reg_wdata,
  output logic [BYTE_W-1:0]      reg_rdata,
  output logic                   glob_en,
  output logic                   dual_mode,
  output chan_cfg_t [N_CH-1:0]   cfg
);
  logic [3:0]        ctrl_q;
  logic [3:0]        dir_q;
  logic [BYTE_W-1:0] hi_q [N_CH];
  logic [BYTE_W-1:0] lo_q [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      for (int i = 0; i < N_CH; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else if (reg_wr) begin
      case (reg_sel)
        OFF_CTRL: ctrl_q   <= reg_wdata[3:0];
        OFF_DIR:  dir_q    <= reg_wdata[3:0];
        OFF_C0HI: hi_q[0]  <= reg_wdata;
        OFF_C0LO: lo_q[0]  <= reg_wdata;
        OFF_C1HI: hi_q[1]  <= reg_wdata;
        OFF_C1LO: lo_q[1]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      OFF_CTRL: reg_rdata[3:0] = ctrl_q;
      OFF_DIR:  reg_rdata[3:0] = dir_q;
      OFF_C0HI: reg_rdata      = hi_q[0];
      OFF_C0LO: reg_rdata      = lo_q[0];
      OFF_C1HI: reg_rdata      = hi_q[1];
      OFF_C1LO: reg_rdata      = lo_q[1];
      default:  reg_rdata      = '0;
    endcase
  end

  assign glob_en   = ctrl_q[0];
  assign dual_mode = ctrl_q[1];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_cfg
      assign cfg[c].lo_en  = ctrl_q[2+c];
      assign cfg[c].dir_en = dir_q[2*c+1];
      assign cfg[c].dir_rd = dir_q[2*c];
      assign cfg[c].hi     = hi_q[c];
      assign cfg[c].lo     = lo_q[c];
    end
  endgenerate

  // R10: a byte written to the channel 0 high offset is held there afterwards
  a_r10_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == OFF_C0HI) |=> (hi_q[0] == $past(reg_wdata)));
  // R10: unmapped offsets read zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel > OFF_C1LO) |-> (reg_rdata == '0));
endmodule

// File: rtl/bbc_chan_cmp.sv
module bbc_chan_cmp
  import bbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic              dir_apply,
  input  logic              allow,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  output logic              match_q
);
  logic hi_eq, lo_ok, dir_ok, hit;

  always_comb begin
    hi_eq  = (bus_addr[ADDR_W-1:BYTE_W] == cfg.hi);
    lo_ok  = !cfg.lo_en || (bus_addr[BYTE_W-1:0] == cfg.lo);
    dir_ok = !(dir_apply && cfg.dir_en) || (bus_read == cfg.dir_rd);
    hit    = allow && bus_valid && hi_eq && lo_ok && dir_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= hit;
  end

  // R3: no pulse after an invalid cycle
  a_r3_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !match_q);
  // R3: no pulse after a high-byte mismatch
  a_r3_hi_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:BYTE_W] != cfg.hi) |=> !match_q);
  // R2: gated-off channel stays quiet
  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !match_q);
  // R4: low byte mismatch blocks when the low byte is in the compare
  a_r4_lo_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lo_en && bus_addr[BYTE_W-1:0] != cfg.lo) |=> !match_q);
  // R6: wrong direction blocks when direction compare is active
  a_r6_wrong_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_apply && cfg.dir_en && bus_read != cfg.dir_rd) |=> !match_q);
endmodule

// File: rtl/bus_brk_cmp.sv
module bus_brk_cmp
  import bbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  output logic              match0,
  output logic              match1
);
  logic                 glob_en, dual_mode;
  chan_cfg_t [N_CH-1:0] cfg;
  logic [N_CH-1:0]      match_v;

  bbc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .glob_en(glob_en), .dual_mode(dual_mode), .cfg(cfg)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic in_use;
      assign in_use = (c == 0) ? 1'b1 : dual_mode;
      bbc_chan_cmp u_cmp (
        .clk(clk), .rst_n(rst_n), .cfg(cfg[c]),
        .dir_apply(in_use), .allow(glob_en && in_use),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_read(bus_read),
        .match_q(match_v[c])
      );
    end
  endgenerate

  assign match0 = match_v[0];
  assign match1 = match_v[1];

  // R7: full mode keeps channel 1 quiet
  a_r7_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |=> !match1);
  // R2: global disable silences both outputs
  a_r2_both_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> (!match0 && !match1));
endmodule

// File: tb/bus_brk_cmp_bench.sv
module bus_brk_cmp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_sel = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic       bus_read = 1'b0;
  logic       match0, match1;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_brk_cmp u_bus_brk_cmp (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_read(bus_read), .match0(match0), .match1(match1)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_sel = s; #1;
    check(reg_rdata, exp, tag, $sformatf("read offset %0d", s));
  endtask

  // bench-side configuration copy
  logic en, dual, le0, le1, de0, dr0, de1, dr1;
  logic [7:0] h0 = 8'h5A, l0 = 8'h3C, h1 = 8'hA5, l1 = 8'hC3;

  function automatic logic expect_hit(input int ch, input logic v, input logic [15:0] a, input logic r);
    logic [7:0] h, l; logic le, de, dr, use_ch;
    h = ch == 0 ? h0 : h1;  l = ch == 0 ? l0 : l1;
    le = ch == 0 ? le0 : le1; de = ch == 0 ? de0 : de1; dr = ch == 0 ? dr0 : dr1;
    use_ch = ch == 0 ? 1'b1 : dual;
    return en && use_ch && v && (a[15:8] == h) && (!le || a[7:0] == l) && (!de || r == dr);
  endfunction

  function automatic string tag_for(input int ch, input logic v, input logic [15:0] a, input logic r);
    logic [7:0] h, l; logic de;
    h = ch == 0 ? h0 : h1; l = ch == 0 ? l0 : l1; de = ch == 0 ? de0 : de1;
    if (!en) return "R2";
    if (ch == 1 && !dual) return "R7";
    if (!v || a[15:8] != h) return "R3";
    if (a[7:0] != l) return "R4";
    if (ch == 1) return "R8";
    return de ? "R6" : "R5";
  endfunction

  initial begin
    logic [15:0] addrs [6];
    addrs[0] = 16'h5A3C; addrs[1] = 16'h5A3D; addrs[2] = 16'hDA3C;
    addrs[3] = 16'hA5C3; addrs[4] = 16'hA5D3; addrs[5] = 16'hA4C3;

    #9 rst_n = 1'b1;
    // R1: reset state
    check({7'd0, match0}, 8'd0, "R1", "match0 after reset");
    check({7'd0, match1}, 8'd0, "R1", "match1 after reset");
    for (int s = 0; s < 8; s++) rd_check(3'(s), 8'h00, "R1");

    // R10: layout and masks
    for (int s = 0; s < 8; s++) wr(3'(s), 8'hFF);
    rd_check(3'd0, 8'h0F, "R10"); rd_check(3'd1, 8'h0F, "R10");
    for (int s = 2; s < 6; s++) rd_check(3'(s), 8'hFF, "R10");
    rd_check(3'd6, 8'h00, "R10"); rd_check(3'd7, 8'h00, "R10");

    wr(3'd2, h0); wr(3'd3, l0); wr(3'd4, h1); wr(3'd5, l1);

    // Sweep every control/direction combination over a set of bus patterns
    for (int k = 0; k < 256; k++) begin
      en = k[0]; dual = k[1]; le0 = k[2]; le1 = k[3];
      dr0 = k[4]; de0 = k[5]; dr1 = k[6]; de1 = k[7];
      wr(3'd0, {4'd0, le1, le0, dual, en});
      wr(3'd1, {4'd0, de1, dr1, de0, dr0});
      for (int ai = 0; ai < 6; ai++)
        for (int rr = 0; rr < 2; rr++)
          for (int vv = 0; vv < 2; vv++) begin
            @(negedge clk);
            bus_valid = vv[0]; bus_addr = addrs[ai]; bus_read = rr[0];
            @(negedge clk);
            check({7'd0, match0}, {7'd0, expect_hit(0, vv[0], addrs[ai], rr[0])},
                  tag_for(0, vv[0], addrs[ai], rr[0]),
                  $sformatf("ch0 cfg %0h addr %h rd %0d v %0d", k, addrs[ai], rr, vv));
            check({7'd0, match1}, {7'd0, expect_hit(1, vv[0], addrs[ai], rr[0])},
                  tag_for(1, vv[0], addrs[ai], rr[0]),
                  $sformatf("ch1 cfg %0h addr %h rd %0d v %0d", k, addrs[ai], rr, vv));
            bus_valid = 1'b0;
          end
    end

    // R3: a held valid cycle pulses once per cycle, then drops
    wr(3'd0, 8'h05); wr(3'd1, 8'h00);
    @(negedge clk); bus_valid = 1'b1; bus_addr = 16'h5A3C;
    @(negedge clk); bus_valid = 1'b0;
    check({7'd0, match0}, 8'd1, "R3", "pulse after single cycle");
    @(negedge clk);
    check({7'd0, match0}, 8'd0, "R3", "pulse lasts one cycle");

    // R9: write on the same edge as a bus cycle uses old values
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'h5A3C;
    reg_sel = 3'd2; reg_wdata = 8'h11; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    check({7'd0, match0}, 8'd1, "R9", "same-edge cycle compared with old high byte");
    @(negedge clk); bus_valid = 1'b0;
    check({7'd0, match0}, 8'd0, "R9", "next cycle uses new high byte");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule